// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Arbiter

This block holds the interrupt state shared by two serial channels, A and B. For each channel it keeps a receive-pending flag, a transmit-pending flag and one in-service flag for each of the two. From these it builds a six-bit pending register, an eight-bit interrupt vector and a single interrupt line. The interrupt line is the OR of the two channels' requests.

Channel logic drives one-cycle pulses into the block. Set pulses raise a source. Clear pulses drop it. A reset-in-service pulse ends service of the highest source, and a per-channel reset clears that channel's flags. The enable fields from the channel's control registers are held inputs, as is the break status. On each channel, receive service and transmit service exclude each other. When one source is cleared, the vector reads "none" for that step, and the other source is presented again if it is still pending.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After `rst_n` is released, every flag is clear, `pend` is 0 (break inputs low), `vector` is 0x06 and `irq` is 0.
- R2: A channel requests only when its `gie` input is 1 and at least one of these holds: `tie` is 1 and transmit is pending; `rx_mode` is 01 or 10 and receive is pending; `bie` is 1 and `brk` is 1. An `rx_mode` of 00 or 11 never requests.
- R3: `irq` is the OR of the requests of channel A and channel B.
- R4: `pend` layout: bit 0 is B break (`brk_b & bie_b`), bit 1 is B transmit pending, bit 2 is B receive pending, bit 3 is A break, bit 4 is A transmit pending, bit 5 is A receive pending.
- R5: The vector codes are chosen when `vec_hi` is 0. None is 0x06, receive A is 0x0C, receive B is 0x04, transmit A is 0x08 and transmit B is 0x00.
- R6: The vector codes are chosen when `vec_hi` is 1. None is 0x60, receive A is 0x30, receive B is 0x20, transmit A is 0x10 and transmit B is 0x00. The code is taken from the value of `vec_hi` in the cycle of the update.
- R7: A receive set marks receive pending. It also takes receive into service and loads the receive code, but only if transmit is not in service on that channel. A transmit set works the same way, with receive in service as its blocker.
- R8: A receive or transmit clear drops that source's pending and in-service flags and loads "none". If the other source of that channel is still pending, it is then presented as a set of that source.
- R9: A reset-in-service pulse ends receive service if receive is in service, and otherwise ends transmit service. It leaves `vector` and `pend` unchanged.
- R10: A channel reset clears all four flags of that channel, and only that channel. It overrides the other pulses for that channel and leaves `vector` unchanged.
- R11: Within one cycle, channel B events are applied before channel A events, so A's code is the one that remains. Within a channel the order is clears, then reset-in-service, then sets. All results appear one clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the whole block |
| vec_hi | input | 1 | Selects the high vector encoding |
| crst_a | input | 1 | Channel A reset pulse |
| crst_b | input | 1 | Channel B reset pulse |
| rx_set_a | input | 1 | Raise receive interrupt, channel A |
| rx_set_b | input | 1 | Raise receive interrupt, channel B |
| tx_set_a | input | 1 | Raise transmit interrupt, channel A |
| tx_set_b | input | 1 | Raise transmit interrupt, channel B |
| rx_clr_a | input | 1 | Clear receive interrupt, channel A |
| rx_clr_b | input | 1 | Clear receive interrupt, channel B |
| tx_clr_a | input | 1 | Clear transmit interrupt, channel A |
| tx_clr_b | input | 1 | Clear transmit interrupt, channel B |
| ius_rst_a | input | 1 | End highest in-service, channel A |
| ius_rst_b | input | 1 | End highest in-service, channel B |
| gie_a | input | 1 | Master interrupt enable, channel A |
| gie_b | input | 1 | Master interrupt enable, channel B |
| tie_a | input | 1 | Transmit interrupt enable, channel A |
| tie_b | input | 1 | Transmit interrupt enable, channel B |
| rx_mode_a | input | 2 | Receive interrupt mode, channel A |
| rx_mode_b | input | 2 | Receive interrupt mode, channel B |
| bie_a | input | 1 | Break interrupt enable, channel A |
| bie_b | input | 1 | Break interrupt enable, channel B |
| brk_a | input | 1 | Break status, channel A |
| brk_b | input | 1 | Break status, channel B |
| pend | output | 6 | Shared interrupt-pending register |
| vector | output | 8 | Modified interrupt vector |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted in-service flag first shows up at the next set or clear of the other source on that channel. In that cycle the vector keeps a stale code where a fresh one was due, or changes where it should have held. This is why the stimulus chains sets, clears and reset-in-service pulses, and compares `vector` one clock after each pulse. A wrong pending flag appears at once in `pend` and usually in `irq`, one cycle after the pulse that caused it. Same-cycle pulses on both channels check the channel order, because a reversed order leaves the wrong channel's code in `vector`.

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vec_hi,
  input  logic       crst_a,
  input  logic       crst_b,
  input  logic       rx_set_a,
  input  logic       rx_set_b,
  input  logic       tx_set_a,
  input  logic       tx_set_b,
  input  logic       rx_clr_a,
  input  logic       rx_clr_b,
  input  logic       tx_clr_a,
  input  logic       tx_clr_b,
  input  logic       ius_rst_a,
  input  logic       ius_rst_b,
  input  logic       gie_a,
  input  logic       gie_b,
  input  logic       tie_a,
  input  logic       tie_b,
  input  logic [1:0] rx_mode_a,
  input  logic [1:0] rx_mode_b,
  input  logic       bie_a,
  input  logic       bie_b,
  input  logic       brk_a,
  input  logic       brk_b,
  output logic [5:0] pend,
  output logic [7:0] vector,
  output logic       irq
);

  // index 1 = channel A, index 0 = channel B
  logic [1:0] rxp, txp, rxs, txs;
  logic [1:0] n_rxp, n_txp, n_rxs, n_txs;
  logic [7:0] vec_q, n_vec;

  wire [1:0] crst = {crst_a, crst_b};
  wire [1:0] rset = {rx_set_a, rx_set_b};
  wire [1:0] tset = {tx_set_a, tx_set_b};
  wire [1:0] rclr = {rx_clr_a, rx_clr_b};
  wire [1:0] tclr = {tx_clr_a, tx_clr_b};
  wire [1:0] ius  = {ius_rst_a, ius_rst_b};

  wire [7:0] code_none = vec_hi ? 8'h60 : 8'h06;

  function automatic logic [7:0] rx_code(input logic hi, input logic is_a);
    if (is_a) return hi ? 8'h30 : 8'h0C;
    return hi ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [7:0] tx_code(input logic hi, input logic is_a);
    if (is_a) return hi ? 8'h10 : 8'h08;
    return 8'h00;
  endfunction

  always_comb begin
    n_rxp = rxp;
    n_txp = txp;
    n_rxs = rxs;
    n_txs = txs;
    n_vec = vec_q;
    for (int c = 0; c < 2; c++) begin
      if (crst[c]) begin
        n_rxp[c] = 1'b0;
        n_txp[c] = 1'b0;
        n_rxs[c] = 1'b0;
        n_txs[c] = 1'b0;
      end else begin
        if (rclr[c]) begin
          n_rxp[c] = 1'b0;
          n_rxs[c] = 1'b0;
          n_vec    = code_none;
          if (n_txp[c] && !n_rxs[c]) begin
            n_txs[c] = 1'b1;
            n_vec    = tx_code(vec_hi, c == 1);
          end
        end
        if (tclr[c]) begin
          n_txp[c] = 1'b0;
          n_txs[c] = 1'b0;
          n_vec    = code_none;
          if (n_rxp[c] && !n_txs[c]) begin
            n_rxs[c] = 1'b1;
            n_vec    = rx_code(vec_hi, c == 1);
          end
        end
        if (ius[c]) begin
          if (n_rxs[c]) n_rxs[c] = 1'b0;
          else          n_txs[c] = 1'b0;
        end
        if (rset[c]) begin
          n_rxp[c] = 1'b1;
          if (!n_txs[c]) begin
            n_rxs[c] = 1'b1;
            n_vec    = rx_code(vec_hi, c == 1);
          end
        end
        if (tset[c]) begin
          n_txp[c] = 1'b1;
          if (!n_rxs[c]) begin
            n_txs[c] = 1'b1;
            n_vec    = tx_code(vec_hi, c == 1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxp   <= '0;
      txp   <= '0;
      rxs   <= '0;
      txs   <= '0;
      vec_q <= 8'h06;
    end else begin
      rxp   <= n_rxp;
      txp   <= n_txp;
      rxs   <= n_rxs;
      txs   <= n_txs;
      vec_q <= n_vec;
    end
  end

  wire brk_ev_a = brk_a & bie_a;
  wire brk_ev_b = brk_b & bie_b;
  wire rx_on_a  = (rx_mode_a == 2'b01) || (rx_mode_a == 2'b10);
  wire rx_on_b  = (rx_mode_b == 2'b01) || (rx_mode_b == 2'b10);
  wire req_a    = gie_a & ((tie_a & txp[1]) | (rx_on_a & rxp[1]) | brk_ev_a);
  wire req_b    = gie_b & ((tie_b & txp[0]) | (rx_on_b & rxp[0]) | brk_ev_b);

  assign pend   = {rxp[1], txp[1], brk_ev_a, rxp[0], txp[0], brk_ev_b};
  assign vector = vec_q;
  assign irq    = req_a | req_b;

  assert_service_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxs[0] && txs[0]) && !(rxs[1] && txs[1]));

  assert_service_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rxs & ~rxp) == 2'b00) && ((txs & ~txp) == 2'b00));

  assert_rx_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr_a && !rx_set_a) |=> !pend[5]);

  assert_no_enable_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_a && !gie_b) |-> !irq);

  assert_chan_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    crst_b |=> (pend[2:1] == 2'b00));

  assert_vector_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vector == 8'h06 || vector == 8'h0C || vector == 8'h04 || vector == 8'h08 ||
    vector == 8'h00 || vector == 8'h60 || vector == 8'h30 || vector == 8'h20 ||
    vector == 8'h10);

endmodule

// File: tb/irq_vec_arbiter_tb.sv
module irq_vec_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_hi = 1'b0;
  logic crst_a = 0, crst_b = 0, rx_set_a = 0, rx_set_b = 0, tx_set_a = 0, tx_set_b = 0;
  logic rx_clr_a = 0, rx_clr_b = 0, tx_clr_a = 0, tx_clr_b = 0, ius_rst_a = 0, ius_rst_b = 0;
  logic gie_a = 1, gie_b = 1, tie_a = 1, tie_b = 1, bie_a = 0, bie_b = 0, brk_a = 0, brk_b = 0;
  logic [1:0] rx_mode_a = 2'b01, rx_mode_b = 2'b01;
  logic [5:0] pend;
  logic [7:0] vector;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_vec_arbiter dut_i (.*);

  // {stim[12:0], pend[5:0], vector[7:0], irq}
  // stim bits: 0 rxset_a 1 rxset_b 2 txset_a 3 txset_b 4 rxclr_a 5 rxclr_b
  // 6 txclr_a 7 txclr_b 8 ius_a 9 ius_b 10 crst_a 11 crst_b 12 vec_hi
  localparam int NV = 22;
  localparam logic [27:0] TBL [NV] = '{
    {13'h0001, 6'b100000, 8'h0C, 1'b1},  // R5 R7
    {13'h0004, 6'b110000, 8'h0C, 1'b1},  // R7 blocked
    {13'h0010, 6'b010000, 8'h08, 1'b1},  // R8 re-present tx
    {13'h0001, 6'b110000, 8'h08, 1'b1},  // R7 blocked
    {13'h0040, 6'b100000, 8'h0C, 1'b1},  // R8 re-present rx
    {13'h0010, 6'b000000, 8'h06, 1'b0},  // R8 none
    {13'h1002, 6'b000100, 8'h20, 1'b1},  // R6
    {13'h1008, 6'b000110, 8'h20, 1'b1},  // R7
    {13'h1020, 6'b000010, 8'h00, 1'b1},  // R6 R8
    {13'h0080, 6'b000000, 8'h06, 1'b0},  // R5
    {13'h1004, 6'b010000, 8'h10, 1'b1},  // R6
    {13'h0100, 6'b010000, 8'h10, 1'b1},  // R9
    {13'h0001, 6'b110000, 8'h0C, 1'b1},  // R9 service ended
    {13'h1040, 6'b100000, 8'h30, 1'b1},  // R6 R8
    {13'h0100, 6'b100000, 8'h30, 1'b1},  // R9
    {13'h0004, 6'b110000, 8'h08, 1'b1},  // R9 R5
    {13'h0008, 6'b110010, 8'h00, 1'b1},  // R5
    {13'h0400, 6'b000010, 8'h00, 1'b1},  // R10
    {13'h0003, 6'b100110, 8'h0C, 1'b1},  // R11 B then A
    {13'h0C00, 6'b000000, 8'h0C, 1'b0},  // R10
    {13'h0011, 6'b100000, 8'h0C, 1'b1},  // R11 clear then set
    {13'h0010, 6'b000000, 8'h06, 1'b0}   // R8
  };

  task automatic check(input string req, input logic [5:0] ep, input logic [7:0] ev, input logic ei);
    n_run++;
    if (pend !== ep || vector !== ev || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: pend=%b vector=%h irq=%b expected pend=%b vector=%h irq=%b",
               req, pend, vector, irq, ep, ev, ei);
    end
  endtask

  task automatic apply(input logic [12:0] s);
    @(negedge clk);
    {vec_hi, crst_b, crst_a, ius_rst_b, ius_rst_a, tx_clr_b, tx_clr_a,
     rx_clr_b, rx_clr_a, tx_set_b, tx_set_a, rx_set_b, rx_set_a} = s;
    @(negedge clk);
    {crst_b, crst_a, ius_rst_b, ius_rst_a, tx_clr_b, tx_clr_a,
     rx_clr_b, rx_clr_a, tx_set_b, tx_set_a, rx_set_b, rx_set_a} = '0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 6'b000000, 8'h06, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][27:15]);
      check($sformatf("R5-R11 vector step %0d", i), TBL[i][14:9], TBL[i][8:1], TBL[i][0]);
    end

    apply(13'h0001);
    check("R2", 6'b100000, 8'h0C, 1'b1);
    rx_mode_a = 2'b00; #1 check("R2 mode00", 6'b100000, 8'h0C, 1'b0);
    rx_mode_a = 2'b11; #1 check("R2 mode11", 6'b100000, 8'h0C, 1'b0);
    rx_mode_a = 2'b10; #1 check("R2 mode10", 6'b100000, 8'h0C, 1'b1);
    gie_a = 1'b0;      #1 check("R2 gie off", 6'b100000, 8'h0C, 1'b0);
    gie_a = 1'b1; rx_mode_a = 2'b00; brk_a = 1'b1; bie_a = 1'b1;
    #1 check("R2 R4 break A", 6'b101000, 8'h0C, 1'b1);
    bie_a = 1'b0;      #1 check("R2 break masked", 6'b100000, 8'h0C, 1'b0);
    brk_b = 1'b1; bie_b = 1'b1;
    #1 check("R3 R4 break B", 6'b100001, 8'h0C, 1'b1);
    gie_b = 1'b0;      #1 check("R3 both off", 6'b100001, 8'h0C, 1'b0);
    gie_b = 1'b1; brk_b = 1'b0;
    apply(13'h0004);
    tie_a = 1'b0;      #1 check("R2 tie off", 6'b110000, 8'h0C, 1'b0);
    tie_a = 1'b1;      #1 check("R2 tie on", 6'b110000, 8'h0C, 1'b1);

    rst_n = 1'b0;
    #1 check("R1 reset again", 6'b000000, 8'h06, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule